// File: doc/BRIEF.md
# Low-Side Switch PWM Gate Guard

This block drives the gate enables of a bank of low-side power switches. For every channel it forms a gate request from a stored on/off command and one PWM pin shared by the whole bank. A per-channel enable bit decides whether PWM takes part at all. A per-channel combine bit then chooses whether the pin is ANDed or ORed with the command. The request then passes a protection stage before it reaches the gate. That stage holds one state machine for overvoltage, shared by all channels, and one state machine per channel for overtemperature and short circuit. Each state machine has its own recovery policy.

The control bits come from a register file outside this block. That file pulses `commit` in the cycle in which a new command word takes effect. The analog front end supplies a global overvoltage flag and, per channel, an overtemperature flag and a drain-to-source "voltage high" comparator flag. The block returns the gate enables and the fault flags that a status word is built from. The gate outputs are combinational from the current control inputs and the registered protection state, so a PWM edge reaches the gate in the same cycle.

The overvoltage machine has three states: OV_NORMAL, OV_TRIP and OV_LOCK. Its transitions are:
- OV_NORMAL to OV_TRIP when the overvoltage flag is high.
- OV_TRIP to OV_NORMAL when the flag clears and resume is selected.
- OV_TRIP to OV_LOCK when the flag clears and stay-off is selected.
- OV_LOCK to OV_TRIP when the flag rises again.
- OV_LOCK to OV_NORMAL on a commit.

Each channel machine also has three states: CH_RUN, CH_COOL and CH_HOLD. Its transitions are:
- CH_RUN to CH_COOL on overtemperature.
- CH_RUN to CH_HOLD when the short timer expires.
- CH_COOL to CH_RUN on cooling when retry is selected or the channel is commanded off.
- CH_COOL to CH_HOLD on cooling otherwise.
- CH_HOLD to CH_COOL on overtemperature.
- CH_HOLD to CH_RUN when the channel is commanded off or on a commit.

Top module: `lsd_gate_guard`

## Requirements
- R1: For a channel whose PWM-enable bit is 0, the gate equals its on/off bit while no protective shutdown is active.
- R2: For a channel whose PWM-enable bit is 1 and whose combine bit is 0, the gate is the on/off bit AND the PWM pin.
- R3: For a channel whose PWM-enable bit is 1 and whose combine bit is 1, the gate is the on/off bit OR the PWM pin. A gate is never high unless its on/off bit is high or the channel is in OR mode with the pin high.
- R4: One clock edge after the overvoltage flag is sampled high, all gates are 0 and both `ov_fault` and `any_fault` are 1.
- R5: With `ov_resume` = 1, one edge after the overvoltage flag is sampled low, the gates follow their commanded states again and `ov_fault` returns to 0.
- R6: With `ov_resume` = 0, all gates stay 0 and `ov_fault` stays 1 after the overvoltage flag clears, until a `commit` pulse is sampled. One edge after that pulse, the gates resume.
- R7: One edge after a channel's overtemperature flag is sampled high, that channel's gate is 0 and its `out_fault` bit and `any_fault` are 1. Other channels are unaffected.
- R8: With `therm_retry` = 1, one edge after the overtemperature flag is sampled low, the channel's gate resumes and its fault bit clears.
- R9: With `therm_retry` = 0, a cooled channel stays off with its fault bit set. It is released one edge after it is sampled either commanded off or with `commit` high.
- R10: With the channel's `therm_only` bit at 0, the channel is shut off and latched with its fault bit set once its gate has been high and its comparator flag high on SHORT_TICKS consecutive clock edges. The latch clears like R9.
- R11: The short timer restarts whenever the comparator flag is low or the gate is low on an edge. Runs of SHORT_TICKS-1 edges that are broken this way never trip.
- R12: With the channel's `therm_only` bit at 1, the comparator flag never shuts the channel off.
- R13: Active-low reset clears every latched shutdown and all fault flags at once. After reset, gates follow R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | One-cycle pulse: a new command word has taken effect |
| on_cmd | input | N_OUT | Per-channel on/off command |
| pwm_en | input | N_OUT | Per-channel PWM participation enable |
| or_mode | input | N_OUT | Per-channel combine select: 0 = AND, 1 = OR |
| therm_only | input | N_OUT | Per-channel: 1 = ignore short comparator and rely on thermal only |
| ov_resume | input | 1 | 1 = resume after overvoltage, 0 = stay off until commit |
| therm_retry | input | 1 | 1 = retry after cooling, 0 = latch off |
| pwm_in | input | 1 | Shared PWM pin |
| ov_flag | input | 1 | Supply overvoltage detected |
| ot_flag | input | N_OUT | Per-channel overtemperature |
| vds_hi | input | N_OUT | Per-channel drain-to-source voltage high |
| gate | output | N_OUT | Gate enables |
| out_fault | output | N_OUT | Per-channel protective shutdown active |
| ov_fault | output | 1 | Overvoltage shutdown active |
| any_fault | output | 1 | Any shutdown active |

## Verification
The hardest situation to reach from the ports is the edge of the short timer. The comparator must stay high for exactly SHORT_TICKS-1 edges and then drop, or the gate must be pulled low for one cycle inside such a run. Both must leave the channel running, while one more edge must trip it. The bench shortens SHORT_TICKS and drives the comparator on counted falling edges to land on both sides of that boundary. A long pseudo-random phase then overlaps PWM toggling with overvoltage and thermal events and release pulses, checked against a cycle model on every clock.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef enum logic [1:0] {
        CH_RUN  = 2'd0,
        CH_COOL = 2'd1,
        CH_HOLD = 2'd2
    } chan_state_t;

    typedef enum logic [1:0] {
        OV_NORMAL = 2'd0,
        OV_TRIP   = 2'd1,
        OV_LOCK   = 2'd2
    } ov_state_t;

endpackage

// File: rtl/lsd_pwm_mix.sv
module lsd_pwm_mix #(
    parameter int N_OUT = 16
) (
    input  logic [N_OUT-1:0] on_cmd,
    input  logic [N_OUT-1:0] pwm_en,
    input  logic [N_OUT-1:0] or_mode,
    input  logic             pwm_in,
    output logic [N_OUT-1:0] req
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_mix
        always_comb begin
            if (!pwm_en[i]) begin
                req[i] = on_cmd[i];
            end else if (or_mode[i]) begin
                req[i] = on_cmd[i] | pwm_in;
            end else begin
                req[i] = on_cmd[i] & pwm_in;
            end
        end
    end

endmodule

// File: rtl/lsd_ov_fsm.sv
module lsd_ov_fsm
    import lsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ov_flag,
    input  logic ov_resume,
    input  logic commit,
    output logic ov_block
);

    ov_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= OV_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OV_NORMAL: begin
                if (ov_flag) st_d = OV_TRIP;
            end
            OV_TRIP: begin
                if (!ov_flag) st_d = ov_resume ? OV_NORMAL : OV_LOCK;
            end
            OV_LOCK: begin
                if (ov_flag)     st_d = OV_TRIP;
                else if (commit) st_d = OV_NORMAL;
            end
            default: st_d = OV_NORMAL;
        endcase
    end

    always_comb begin
        ov_block = (st_q != OV_NORMAL);
    end

endmodule

// File: rtl/lsd_chan_fsm.sv
module lsd_chan_fsm
    import lsd_pkg::*;
#(
    parameter int SHORT_TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic req,
    input  logic on_bit,
    input  logic therm_only,
    input  logic therm_retry,
    input  logic ov_block,
    input  logic ot_hot,
    input  logic vds_hi,
    output logic gate,
    output logic fault
);

    localparam int CW = $clog2(SHORT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SHORT_TICKS - 1);

    chan_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          stress;
    logic          short_trip;

    always_comb begin
        stress     = gate && vds_hi && !therm_only;
        short_trip = stress && (cnt_q == LAST);
        cnt_d      = (stress && !short_trip) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_RUN: begin
                if (ot_hot)          st_d = CH_COOL;
                else if (short_trip) st_d = CH_HOLD;
            end
            CH_COOL: begin
                if (!ot_hot) st_d = (therm_retry || !on_bit) ? CH_RUN : CH_HOLD;
            end
            CH_HOLD: begin
                if (ot_hot)                  st_d = CH_COOL;
                else if (!on_bit || commit)  st_d = CH_RUN;
            end
            default: st_d = CH_RUN;
        endcase
    end

    always_comb begin
        gate  = (st_q == CH_RUN) && !ov_block && req;
        fault = (st_q != CH_RUN);
    end

endmodule

// File: rtl/lsd_gate_guard.sv
module lsd_gate_guard #(
    parameter int N_OUT       = 16,
    parameter int SHORT_TICKS = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [N_OUT-1:0] on_cmd,
    input  logic [N_OUT-1:0] pwm_en,
    input  logic [N_OUT-1:0] or_mode,
    input  logic [N_OUT-1:0] therm_only,
    input  logic             ov_resume,
    input  logic             therm_retry,
    input  logic             pwm_in,
    input  logic             ov_flag,
    input  logic [N_OUT-1:0] ot_flag,
    input  logic [N_OUT-1:0] vds_hi,
    output logic [N_OUT-1:0] gate,
    output logic [N_OUT-1:0] out_fault,
    output logic             ov_fault,
    output logic             any_fault
);

    logic [N_OUT-1:0] req;
    logic             ov_block;

    lsd_pwm_mix #(.N_OUT(N_OUT)) u_mix (
        .on_cmd  (on_cmd),
        .pwm_en  (pwm_en),
        .or_mode (or_mode),
        .pwm_in  (pwm_in),
        .req     (req)
    );

    lsd_ov_fsm u_ov (
        .clk       (clk),
        .rst_n     (rst_n),
        .ov_flag   (ov_flag),
        .ov_resume (ov_resume),
        .commit    (commit),
        .ov_block  (ov_block)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        lsd_chan_fsm #(.SHORT_TICKS(SHORT_TICKS)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .commit      (commit),
            .req         (req[i]),
            .on_bit      (on_cmd[i]),
            .therm_only  (therm_only[i]),
            .therm_retry (therm_retry),
            .ov_block    (ov_block),
            .ot_hot      (ot_flag[i]),
            .vds_hi      (vds_hi[i]),
            .gate        (gate[i]),
            .fault       (out_fault[i])
        );
    end

    always_comb begin
        ov_fault  = ov_block;
        any_fault = ov_block || (|out_fault);
    end

endmodule

// File: rtl/lsd_gate_guard_chk.sv
module lsd_gate_guard_chk #(
    parameter int N_OUT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] on_cmd,
    input logic [N_OUT-1:0] pwm_en,
    input logic [N_OUT-1:0] or_mode,
    input logic             pwm_in,
    input logic             ov_flag,
    input logic [N_OUT-1:0] ot_flag,
    input logic [N_OUT-1:0] gate,
    input logic [N_OUT-1:0] out_fault,
    input logic             ov_fault,
    input logic             any_fault
);

    AST_PLAIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en == '0 && !ov_fault && out_fault == '0) |-> (gate == on_cmd)); // R1

    AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gate & ~(on_cmd | (pwm_en & or_mode & {N_OUT{pwm_in}}))) == '0); // R3

    AST_OV_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |=> (ov_fault && any_fault)); // R4

    AST_OV_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault |-> (gate == '0)); // R4

    AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag != '0) |=> ((gate & $past(ot_flag)) == '0)); // R7

    AST_FAULT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fault != '0) |-> any_fault); // R10

endmodule

bind lsd_gate_guard lsd_gate_guard_chk #(.N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_cmd    (on_cmd),
    .pwm_en    (pwm_en),
    .or_mode   (or_mode),
    .pwm_in    (pwm_in),
    .ov_flag   (ov_flag),
    .ot_flag   (ot_flag),
    .gate      (gate),
    .out_fault (out_fault),
    .ov_fault  (ov_fault),
    .any_fault (any_fault)
);

// File: tb/lsd_gate_guard_test.sv
module lsd_gate_guard_test;

    localparam int N  = 16;
    localparam int ST = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         commit;
    logic [N-1:0] on_cmd, pwm_en, or_mode, therm_only, ot_flag, vds_hi;
    logic         ov_resume, therm_retry, pwm_in, ov_flag;
    logic [N-1:0] gate, out_fault;
    logic         ov_fault, any_fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lsd_gate_guard #(.N_OUT(N), .SHORT_TICKS(ST)) uut (
        .clk(clk), .rst_n(rst_n), .commit(commit), .on_cmd(on_cmd),
        .pwm_en(pwm_en), .or_mode(or_mode), .therm_only(therm_only),
        .ov_resume(ov_resume), .therm_retry(therm_retry), .pwm_in(pwm_in),
        .ov_flag(ov_flag), .ot_flag(ot_flag), .vds_hi(vds_hi),
        .gate(gate), .out_fault(out_fault), .ov_fault(ov_fault),
        .any_fault(any_fault)
    );

    // behavioural reference: 0 = running/normal, 1 = hot/tripped, 2 = held/locked
    int m_ov;
    int m_ch [N];
    int m_run [N];

    function automatic logic want_req(int i);
        if (!pwm_en[i]) return on_cmd[i];
        if (or_mode[i]) return on_cmd[i] | pwm_in;
        return on_cmd[i] & pwm_in;
    endfunction

    function automatic logic [N-1:0] want_gate();
        logic [N-1:0] g;
        for (int i = 0; i < N; i++) g[i] = (m_ch[i] == 0) && (m_ov == 0) && want_req(i);
        return g;
    endfunction

    function automatic logic [N-1:0] want_fault();
        logic [N-1:0] f;
        for (int i = 0; i < N; i++) f[i] = (m_ch[i] != 0);
        return f;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ov = 0;
            for (int i = 0; i < N; i++) begin m_ch[i] = 0; m_run[i] = 0; end
        end else begin
            logic [N-1:0] g;
            g = want_gate();
            for (int i = 0; i < N; i++) begin
                bit stressed, tripped;
                stressed = g[i] && vds_hi[i] && !therm_only[i];
                tripped  = stressed && (m_run[i] == ST - 1);
                m_run[i] = (stressed && !tripped) ? m_run[i] + 1 : 0;
                if (m_ch[i] == 0) begin
                    if (ot_flag[i]) m_ch[i] = 1; else if (tripped) m_ch[i] = 2;
                end else if (m_ch[i] == 1) begin
                    if (!ot_flag[i]) m_ch[i] = (therm_retry || !on_cmd[i]) ? 0 : 2;
                end else begin
                    if (ot_flag[i]) m_ch[i] = 1; else if (!on_cmd[i] || commit) m_ch[i] = 0;
                end
            end
            if (m_ov == 0) begin
                if (ov_flag) m_ov = 1;
            end else if (m_ov == 1) begin
                if (!ov_flag) m_ov = ov_resume ? 0 : 2;
            end else begin
                if (ov_flag) m_ov = 1; else if (commit) m_ov = 0;
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            logic [N-1:0] eg, ef;
            eg = want_gate();
            ef = want_fault();
            n_chk++;
            if (gate !== eg || out_fault !== ef || ov_fault !== (m_ov != 0) ||
                any_fault !== ((m_ov != 0) || (ef != 0))) begin
                n_fail++;
                $display("FAIL model R1/R4/R7/R10 gate=%h exp=%h fault=%h exp=%h ov=%b exp=%b any=%b",
                         gate, eg, out_fault, ef, ov_fault, (m_ov != 0), any_fault);
            end
        end
    end

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_commit();
        nxt(); commit = 1'b1;
        nxt(); commit = 1'b0;
    endtask

    initial begin
        int cycles = 0;
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R13 actual=%0d expected=done", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; commit = 1'b0; on_cmd = '0; pwm_en = '0; or_mode = '0;
        therm_only = '0; ot_flag = '0; vds_hi = '0; ov_resume = 1'b1;
        therm_retry = 1'b1; pwm_in = 1'b0; ov_flag = 1'b0;
        cyc(3); #2;
        chk("R13 reset fault", out_fault, '0);
        chk("R13 reset ov/any", {14'd0, ov_fault, any_fault}, '0);
        nxt(); rst_n = 1'b1;

        nxt(); on_cmd = 16'hA5C3; #2 chk("R1 plain", gate, 16'hA5C3);
        nxt(); pwm_en = '1; pwm_in = 1'b0; #2 chk("R2 and low", gate, 16'h0000);
        nxt(); pwm_in = 1'b1; #2 chk("R2 and high", gate, 16'hA5C3);
        nxt(); or_mode = 16'h00FF; #2 chk("R3 or high", gate, 16'hA5FF);
        nxt(); pwm_in = 1'b0; #2 chk("R3 or low", gate, 16'h00C3);

        nxt(); pwm_en = '0; or_mode = '0; on_cmd = '1; ov_flag = 1'b1;
        #2 chk("R4 before edge", gate, 16'hFFFF);
        nxt(); #2 chk("R4 gates off", gate, '0);
        chk("R4 flags", {14'd0, ov_fault, any_fault}, 16'h0003);
        nxt(); ov_flag = 1'b0; #2 chk("R5 still off", gate, '0);
        nxt(); #2 chk("R5 resumed", gate, 16'hFFFF);
        chk("R5 flag", {15'd0, ov_fault}, '0);

        nxt(); ov_resume = 1'b0; ov_flag = 1'b1;
        nxt(); ov_flag = 1'b0;
        cyc(3); #2 chk("R6 locked", gate, '0);
        chk("R6 flag", {15'd0, ov_fault}, 16'h0001);
        pulse_commit(); #2 chk("R6 released", gate, 16'hFFFF);

        nxt(); ot_flag = 16'h0010;
        nxt(); #2 chk("R7 gate", gate, 16'hFFEF);
        chk("R7 fault", out_fault, 16'h0010);
        nxt(); ot_flag = '0;
        nxt(); #2 chk("R8 retry gate", gate, 16'hFFFF);
        chk("R8 retry fault", out_fault, '0);

        nxt(); therm_retry = 1'b0; ot_flag = 16'h0100;
        nxt(); ot_flag = '0;
        cyc(3); #2 chk("R9 latched", gate, 16'hFEFF);
        chk("R9 fault", out_fault, 16'h0100);
        nxt(); on_cmd = 16'hFEFF;
        nxt(); on_cmd = '1; #2 chk("R9 off clears", gate, 16'hFFFF);
        nxt(); ot_flag = 16'h0100;
        nxt(); ot_flag = '0;
        cyc(2); #2 chk("R9 relatched", out_fault, 16'h0100);
        pulse_commit(); #2 chk("R9 commit clears", gate, 16'hFFFF);

        nxt(); vds_hi = 16'h0001;
        cyc(ST - 1); #2 chk("R10 before limit", gate, 16'hFFFF);
        nxt(); #2 chk("R10 tripped", gate, 16'hFFFE);
        chk("R10 fault", out_fault, 16'h0001);
        vds_hi = '0;
        cyc(2); #2 chk("R10 held", gate, 16'hFFFE);
        pulse_commit(); #2 chk("R10 commit clears", gate, 16'hFFFF);

        nxt(); vds_hi = 16'h0001;
        cyc(ST - 2); vds_hi = '0;
        nxt(); vds_hi = 16'h0001;
        cyc(ST - 1); #2 chk("R11 vds gap", gate, 16'hFFFF);
        vds_hi = '0;
        nxt(); vds_hi = 16'h0001;
        cyc(ST - 2); on_cmd = 16'hFFFE;
        nxt(); on_cmd = '1;
        cyc(ST - 1); #2 chk("R11 gate gap", gate, 16'hFFFF);
        vds_hi = '0;

        nxt(); therm_only = 16'h0004; vds_hi = 16'h0004;
        cyc(4 * ST); #2 chk("R12 thermal only", gate, 16'hFFFF);
        chk("R12 fault", out_fault, '0);
        vds_hi = '0;

        nxt(); ot_flag = 16'h0008;
        nxt(); ot_flag = '0;
        cyc(2); #2 chk("R13 pre", out_fault, 16'h0008);
        nxt(); rst_n = 1'b0; #2 chk("R13 cleared", out_fault, '0);
        chk("R13 gate", gate, 16'hFFFF);
        nxt(); rst_n = 1'b1;

        // mixed traffic against the cycle model
        begin
            logic [31:0] lf = 32'h1BADF00D;
            for (int k = 0; k < 3000; k++) begin
                nxt();
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                pwm_in      = lf[0];
                pwm_en      = lf[31:16];
                or_mode     = lf[15:0] ^ lf[31:16];
                ov_resume   = lf[5];
                therm_retry = lf[9];
                commit      = (lf[7:4] == 4'h3);
                ov_flag     = (lf[13:8] == 6'h15);
                ot_flag     = (lf[19:16] == 4'h0) ? (16'h1 << lf[23:20]) : '0;
                vds_hi      = (lf[27:24] < 4'hC) ? 16'h00F0 : '0;
                therm_only  = 16'h0030;
                if (lf[11:10] == 2'b00) on_cmd = lf[27:12];
            end
        end
        nxt();
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule